// File: doc/BRIEF.md
# Interlacing Frame Converter with Three Frame Stores

This block takes progressive video frames, written one pixel per accepted cycle with frame-start and line-start strobes, and hands them through three frame stores to an interlaced reader. The capture store follows the incoming video. The transfer store holds the most recent complete frame. The display store is read for output. Each store keeps even lines and odd lines in separate banks. The reader walks the even bank during one field and the odd bank during the next, which turns a progressive frame into two interlaced fields.

Both sides share one clock. The input rate is set by `in_valid` and the output rate by `out_req`. A finished capture frame is copied into the transfer store only while the transfer store is not being read. At the start of an even field, the transfer store is copied into the display store only while it is not being written. When a copy is blocked, nothing is queued. A blocked input frame is lost, and a blocked display refresh leaves the previous frame on screen. Each copy moves one word per bank per cycle, so it takes `ROWS/2*COLS` cycles.

Top module: `ilace_conv`

## Requirements
- R1: After reset, `out_field` is 1 (odd), `out_pix` is 0, and the transfer store is marked empty, so a vertical sync does not start a copy.
- R2: The input line counter restarts at 0 on `in_sof` and advances on each `in_sol`. Line 0 counts as even. Even lines are stored in the even bank and odd lines in the odd bank, in raster order.
- R3: The pixel at line ROWS-1, column COLS-1 of a frame that began with `in_sof` completes the frame. In the next cycle, a capture-to-transfer copy of `ROWS/2*COLS` cycles begins, unless a transfer-to-display copy is running or starts in the same cycle. In that case the frame is dropped.
- R4: Each `out_vsync` toggles `out_field`, and the new value is visible after the clock edge. A sync that makes the field even (0) starts a transfer-to-display copy only if the transfer store holds a frame and no capture-to-transfer copy is running. Otherwise the display keeps its previous frame.
- R5: `out_vsync` resets the read pointer. Each `out_req` cycle registers the next pixel of the current field on `out_pix`. Field 0 returns lines 0, 2, 4, … and field 1 returns lines 1, 3, 5, …, each line from column 0 upward.
- R6: The two copy engines are never active in the same cycle.
- R7: Pixels requested in the cycles right after an even-field sync that starts a copy already come from the newly copied frame.
- R8: A frame that is restarted by `in_sof` before its last pixel arrives starts no copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input pixel is present this cycle |
| in_sof | input | 1 | Marks the pixel as the first pixel of a frame |
| in_sol | input | 1 | Marks the pixel as the first pixel of a line |
| in_pix | input | PIX_W | Input pixel value |
| out_vsync | input | 1 | Output vertical sync pulse, one cycle long |
| out_req | input | 1 | Request for the next output pixel |
| out_pix | output | PIX_W | Registered output pixel |
| out_field | output | 1 | Current field: 0 for even, 1 for odd |

## Verification
If the line parity or bank address is wrong, pixels leave in the wrong order within the first field read after a copy. The first pixel shows it, or the first pixel of the second line of the field. A broken hand-off rule shows up in the next field read after a conflicting event. If a dropped or blocked frame was copied, a new frame appears where the old one should still be. If an allowed copy was refused, a stale frame remains. A missing forward from the transfer store shows up in the very first pixel requested after an even-field sync.

// File: rtl/ilace_pkg.sv
package ilace_pkg;
    typedef enum logic {
        FIELD_EVEN = 1'b0,
        FIELD_ODD  = 1'b1
    } field_e;
endpackage

// File: rtl/ilace_line_writer.sv
module ilace_line_writer #(
    parameter int COLS = 4,
    parameter int ROWS = 4,
    localparam int DEPTH = (ROWS / 2) * COLS,
    localparam int AW    = $clog2(DEPTH),
    localparam int RW    = $clog2(ROWS) + 1,
    localparam int CW    = $clog2(COLS) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_sol,
    output logic          wr_even,
    output logic          wr_odd,
    output logic [AW-1:0] wr_addr,
    output logic          frame_done
);
    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic          armed;
    } lw_state_t;

    lw_state_t st_q, st_d;
    logic [RW-1:0] cur_row;
    logic [CW-1:0] cur_col;
    logic          in_range;

    always_comb begin
        st_d    = st_q;
        cur_row = st_q.row;
        cur_col = st_q.col;
        if (in_sof) begin
            cur_row = '0;
            cur_col = '0;
        end else if (in_sol) begin
            cur_row = (st_q.row == RW'(ROWS)) ? st_q.row : st_q.row + 1'b1;
            cur_col = '0;
        end else begin
            cur_col = (st_q.col == CW'(COLS)) ? st_q.col : st_q.col + 1'b1;
        end
        in_range   = (cur_row < RW'(ROWS)) && (cur_col < CW'(COLS));
        wr_even    = in_valid && (st_q.armed || in_sof) && in_range && !cur_row[0];
        wr_odd     = in_valid && (st_q.armed || in_sof) && in_range &&  cur_row[0];
        wr_addr    = AW'((cur_row >> 1) * COLS + cur_col);
        frame_done = (wr_even || wr_odd) && (cur_row == RW'(ROWS - 1))
                     && (cur_col == CW'(COLS - 1));
        if (in_valid) begin
            st_d.row = cur_row;
            st_d.col = cur_col;
            if (in_sof)     st_d.armed = 1'b1;
            if (frame_done) st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    p_one_bank_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_even && wr_odd));
    p_done_odd_r2: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (((ROWS - 1) % 2 == 1) ? wr_odd : wr_even));
endmodule

// File: rtl/ilace_copy_engine.sv
module ilace_copy_engine #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          active,
    output logic [AW-1:0] addr,
    output logic          last
);
    typedef struct packed {
        logic          active;
        logic [AW-1:0] cnt;
    } ce_state_t;

    ce_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        last = st_q.active && (st_q.cnt == AW'(DEPTH - 1));
        if (st_q.active) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (last) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end
        end else if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign active = st_q.active;
    assign addr   = st_q.cnt;

    p_full_len_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(addr) == AW'(DEPTH - 1)));
    p_start_zero_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (addr == '0));
endmodule

// File: rtl/ilace_frame_store.sv
module ilace_frame_store #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_even,
    input  logic          we_odd,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata_even,
    input  logic [W-1:0]  wdata_odd,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata_even,
    output logic [W-1:0]  rdata_odd
);
    logic [W-1:0] bank_even [DEPTH];
    logic [W-1:0] bank_odd  [DEPTH];

    always_ff @(posedge clk) begin
        if (we_even) bank_even[waddr] <= wdata_even;
        if (we_odd)  bank_odd[waddr]  <= wdata_odd;
    end

    assign rdata_even = bank_even[raddr];
    assign rdata_odd  = bank_odd[raddr];
endmodule

// File: rtl/ilace_conv.sv
module ilace_conv #(
    parameter int PIX_W = 8,
    parameter int COLS  = 4,
    parameter int ROWS  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_sol,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             out_vsync,
    input  logic             out_req,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_field
);
    import ilace_pkg::*;

    localparam int DEPTH = (ROWS / 2) * COLS;
    localparam int AW    = $clog2(DEPTH);

    typedef struct packed {
        field_e           field;
        logic [AW-1:0]    rptr;
        logic [PIX_W-1:0] pix;
        logic             b_valid;
    } top_state_t;

    top_state_t st_q, st_d;

    logic          cap_we_even, cap_we_odd, cap_done;
    logic [AW-1:0] cap_waddr;
    logic          ab_start, ab_active, ab_last;
    logic [AW-1:0] ab_addr;
    logic          bc_start, bc_active, bc_last;
    logic [AW-1:0] bc_addr;
    logic [PIX_W-1:0] a_even, a_odd, b_even, b_odd, c_even, c_odd;
    logic [PIX_W-1:0] rd_pix;

    ilace_line_writer #(.COLS(COLS), .ROWS(ROWS)) u_writer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .wr_even(cap_we_even), .wr_odd(cap_we_odd),
        .wr_addr(cap_waddr), .frame_done(cap_done)
    );

    ilace_frame_store #(.W(PIX_W), .DEPTH(DEPTH)) u_store_cap (
        .clk(clk), .we_even(cap_we_even), .we_odd(cap_we_odd),
        .waddr(cap_waddr), .wdata_even(in_pix), .wdata_odd(in_pix),
        .raddr(ab_addr), .rdata_even(a_even), .rdata_odd(a_odd)
    );

    ilace_frame_store #(.W(PIX_W), .DEPTH(DEPTH)) u_store_mid (
        .clk(clk), .we_even(ab_active), .we_odd(ab_active),
        .waddr(ab_addr), .wdata_even(a_even), .wdata_odd(a_odd),
        .raddr(bc_addr), .rdata_even(b_even), .rdata_odd(b_odd)
    );

    ilace_frame_store #(.W(PIX_W), .DEPTH(DEPTH)) u_store_disp (
        .clk(clk), .we_even(bc_active), .we_odd(bc_active),
        .waddr(bc_addr), .wdata_even(b_even), .wdata_odd(b_odd),
        .raddr(st_q.rptr), .rdata_even(c_even), .rdata_odd(c_odd)
    );

    ilace_copy_engine #(.DEPTH(DEPTH)) u_copy_ab (
        .clk(clk), .rst(rst), .start(ab_start),
        .active(ab_active), .addr(ab_addr), .last(ab_last)
    );

    ilace_copy_engine #(.DEPTH(DEPTH)) u_copy_bc (
        .clk(clk), .rst(rst), .start(bc_start),
        .active(bc_active), .addr(bc_addr), .last(bc_last)
    );

    always_comb begin
        st_d     = st_q;
        bc_start = out_vsync && (st_q.field == FIELD_ODD) && st_q.b_valid && !ab_active;
        ab_start = cap_done && !bc_active && !bc_start;
        if (bc_active && (bc_addr == st_q.rptr))
            rd_pix = (st_q.field == FIELD_EVEN) ? b_even : b_odd;
        else
            rd_pix = (st_q.field == FIELD_EVEN) ? c_even : c_odd;
        if (ab_last) st_d.b_valid = 1'b1;
        if (out_vsync) begin
            st_d.field = (st_q.field == FIELD_EVEN) ? FIELD_ODD : FIELD_EVEN;
            st_d.rptr  = '0;
        end else if (out_req) begin
            st_d.pix  = rd_pix;
            st_d.rptr = (st_q.rptr == AW'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.field   <= FIELD_ODD;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_pix   = st_q.pix;
    assign out_field = st_q.field;

    p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(ab_active && bc_active));
    p_field_flip_r4: assert property (@(posedge clk) disable iff (rst)
        out_vsync |=> (out_field != $past(out_field)));
    p_field_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !out_vsync |=> $stable(out_field));
    p_refresh_even_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bc_active) |-> (out_field == FIELD_EVEN));
    p_drop_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (cap_done && bc_active) |=> !ab_active);
endmodule

// File: tb/ilace_conv_test.sv
module ilace_conv_test;
    localparam int PIX_W = 8;
    localparam int COLS  = 4;
    localparam int ROWS  = 4;
    localparam int DEPTH = (ROWS / 2) * COLS;
    localparam int NFR   = 4;
    localparam logic [PIX_W-1:0] BASES [NFR] = '{8'h10, 8'h40, 8'h80, 8'hC3};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic             out_vsync = 1'b0, out_req = 1'b0;
    logic [PIX_W-1:0] out_pix;
    logic             out_field;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ilace_conv #(.PIX_W(PIX_W), .COLS(COLS), .ROWS(ROWS)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_pix(in_pix), .out_vsync(out_vsync),
        .out_req(out_req), .out_pix(out_pix), .out_field(out_field)
    );

    function automatic logic [PIX_W-1:0] pixval(logic [PIX_W-1:0] b, int r, int c);
        return PIX_W'(b + r * COLS + c);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drives npix pixels of a frame; pulses out_vsync at pixel index vs_at
    task automatic send_frame(logic [PIX_W-1:0] b, int npix, int vs_at);
        for (int p = 0; p < npix; p++) begin
            in_valid  = 1'b1;
            in_sof    = (p == 0);
            in_sol    = (p % COLS == 0);
            in_pix    = pixval(b, p / COLS, p % COLS);
            out_vsync = (p == vs_at);
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0; out_vsync = 1'b0;
    endtask

    task automatic vsync(int exp_field);
        out_vsync = 1'b1;
        @(negedge clk);
        out_vsync = 1'b0;
        check("R4 field", int'(out_field), exp_field);
    endtask

    task automatic read_field(logic [PIX_W-1:0] b, int fld, string req);
        for (int i = 0; i < DEPTH; i++) begin
            out_req = 1'b1;
            @(negedge clk);
            check(req, int'(out_pix), int'(pixval(b, 2 * (i / COLS) + fld, i % COLS)));
        end
        out_req = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 field", int'(out_field), 1);
        check("R1 pix", int'(out_pix), 0);
        // R1: no frame yet, even sync must not copy; reads stay deterministic via field toggle
        vsync(0);
        vsync(1);

        // table walk: each frame copied, then both fields read (R2 R3 R5 R7)
        for (int k = 0; k < NFR; k++) begin
            send_frame(BASES[k], ROWS * COLS, -1);
            idle(DEPTH + 2);
            vsync(0);
            read_field(BASES[k], 0, "R2 R5 R7 even field");
            vsync(1);
            read_field(BASES[k], 1, "R2 R5 odd field");
        end

        // R4: even sync during capture-to-transfer copy is blocked, old frame stays
        send_frame(8'h21, ROWS * COLS, -1);
        vsync(0);
        read_field(BASES[NFR-1], 0, "R4 blocked refresh even");
        vsync(1);
        read_field(BASES[NFR-1], 1, "R4 blocked refresh odd");
        idle(DEPTH);
        vsync(0);
        read_field(8'h21, 0, "R4 later refresh");
        vsync(1);

        // R3: frame finishing while transfer-to-display copy runs is dropped
        send_frame(8'h55, ROWS * COLS, ROWS * COLS - 4);
        check("R4 field after sync in frame", int'(out_field), 0);
        read_field(8'h21, 0, "R3 refresh during capture");
        idle(DEPTH);
        vsync(1);
        vsync(0);
        read_field(8'h21, 0, "R3 dropped frame even");
        vsync(1);
        read_field(8'h21, 1, "R3 dropped frame odd");

        // R8: partial frame restarted by a new frame start copies nothing
        send_frame(8'h66, ROWS * COLS - 3, -1);
        idle(DEPTH + 2);
        vsync(0);
        read_field(8'h21, 0, "R8 partial frame");
        vsync(1);

        // R2: frame restart after partial resets line count, complete frame lands correctly
        send_frame(8'h77, ROWS * COLS - 5, -1);
        send_frame(8'h99, ROWS * COLS, -1);
        idle(DEPTH + 2);
        vsync(0);
        read_field(8'h99, 0, "R2 restart even");
        vsync(1);
        read_field(8'h99, 1, "R2 restart odd");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule